// File: doc/BRIEF.md
# Serial Transmit Interrupt Source Selector

This block produces the one transmit interrupt line of a synchronous serial port. A 2-bit source-select register picks which of four events drives that line. The events are a rising edge of the transmit-ready flag, a 16-channel block boundary or end of frame in multichannel slot selection, a transmit frame-sync edge arriving from the serial clock domain, and the setting of the frame-sync error flag. Each qualifying event produces a pulse one CPU-clock cycle wide.

The frame-sync input is asynchronous to the CPU clock. It passes through a two-flop synchronizer and then a rising-edge detector, so each sync pulse gives exactly one interrupt. The frame-sync error flag is sticky. It can be read on its own output whatever source is selected, and only an explicit clear input resets it. The transmitter reset input clears the slot counter. It does not mask the interrupt, so frame-sync interrupts still arrive while the transmitter is held in reset.

Top module: `txint_select`

## Requirements
- R1: After `rst_n` is deasserted, the select register holds 00 (ready-edge source), `xint_o` is 0 and `syncerr_o` is 0. Writing `sel_i` with `sel_we_i` high takes effect from the next clock. The codes are 00 ready edge, 01 slot block, 10 frame sync and 11 sync error.
- R2: With select 00, a 0-to-1 change of `xrdy_i` gives a one-cycle `xint_o` pulse one clock later. A held-high or falling `xrdy_i` gives no pulse.
- R3: With select 01 and `mc_en_i` high, every 16th `slot_stb_i` within a frame gives a one-cycle `xint_o` pulse one clock after that strobe.
- R4: With select 01 and `mc_en_i` high, a strobe with `slot_eof_i` high gives a pulse and restarts the slot count. An end of frame that falls on a 16th slot gives a single pulse.
- R5: With select 01 and `mc_en_i` low, strobes and end-of-frame markers never give a pulse.
- R6: With select 10, each rising edge of `fsync_i` gives exactly one `xint_o` pulse, seen in the third clock after the edge. A held-high `fsync_i` gives no further pulse.
- R7: With select 10, frame-sync pulses still raise `xint_o` while `xmit_rst_n_i` is low.
- R8: With select 11, `xint_o` pulses one clock after `syncerr_set_i` when the flag was clear. A set while the flag is already set gives no pulse.
- R9: `syncerr_o` goes high one clock after `syncerr_set_i` under any select value. It stays high until `syncerr_clr_i`, which clears it one clock later. A set and a clear in the same cycle leave it set.
- R10: Events from sources other than the selected one never give a pulse.
- R11: A low `xmit_rst_n_i` clears the slot count, so the next block boundary comes 16 strobes after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| sel_we_i | input | 1 | Load strobe for the source-select register |
| sel_i | input | 2 | New source-select value |
| xrdy_i | input | 1 | Transmit-ready flag |
| mc_en_i | input | 1 | Multichannel slot selection active |
| slot_stb_i | input | 1 | One-cycle strobe per transmitted channel slot |
| slot_eof_i | input | 1 | Marks the strobed slot as the last of the frame |
| fsync_i | input | 1 | Transmit frame sync, serial clock domain |
| syncerr_set_i | input | 1 | Frame-sync error detected |
| syncerr_clr_i | input | 1 | Clear the frame-sync error flag |
| xmit_rst_n_i | input | 1 | Transmitter reset, active low |
| xint_o | output | 1 | Transmit interrupt pulse |
| syncerr_o | output | 1 | Sticky frame-sync error flag |

## Verification
The ready-edge, slot-boundary and error sources all update `xint_o` on the first clock edge after their stimulus, and `syncerr_o` follows a set or clear with the same one-cycle delay. The frame-sync source crosses two synchronizer flops and the output register, so its pulse is due in the third cycle after the edge. Inputs change on the falling edge and outputs are read on later falling edges. Each scenario counts those edges to the cycle where its result is due, and it also checks the cycles on either side so that a pulse that is early, late or stretched is caught.

// File: rtl/txint_pkg.sv
// Shared types for the transmit interrupt selector.
// Assumes: the select code is the 2-bit value written by software.
package txint_pkg;
    typedef enum logic [1:0] {
        TXI_RDY = 2'b00,
        TXI_BLK = 2'b01,
        TXI_FS  = 2'b10,
        TXI_ERR = 2'b11
    } txi_sel_e;
endpackage

// File: rtl/txint_fs_sync.sv
// Brings the frame-sync level into the CPU clock and flags its rising edge.
// Assumes: fsync is held for at least STAGES+1 CPU cycles per pulse.
module txint_fs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES:0] chain_q;

    // Shift the level through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], async_i};
    end

    assign rise_o = chain_q[LAST] & ~chain_q[STAGES];

    AST_FS_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R6
endmodule

// File: rtl/txint_blk_track.sv
// Counts channel-slot strobes in blocks of BLK and flags block or frame end.
// Assumes: one strobe per slot; the counter is idle while selection is off.
module txint_blk_track #(
    parameter int BLK = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_n_i,
    input  logic en_i,
    input  logic stb_i,
    input  logic eof_i,
    output logic evt_o
);
    localparam int CNT_W = (BLK > 1) ? $clog2(BLK) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             last_slot;

    assign last_slot = (cnt_q == LAST);
    assign evt_o     = en_i & stb_i & (last_slot | eof_i);

    // Advance the slot count; restart at block end, frame end or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_n_i || !en_i) cnt_q <= '0;
        else if (stb_i)                  cnt_q <= (eof_i || last_slot) ? '0 : cnt_q + 1'b1;
    end

    AST_EOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && eof_i) |=> (cnt_q == '0)); // R4
    AST_XRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run_n_i |=> (cnt_q == '0)); // R11
endmodule

// File: rtl/txint_err_flag.sv
// Sticky frame-sync error flag with a set-edge output for the interrupt.
// Assumes: set takes priority over clear in the same cycle.
module txint_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o,
    output logic rise_o
);
    logic flag_q;

    // Hold the flag until an explicit clear without a concurrent set.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
    assign rise_o = set_i & ~flag_q;

    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o); // R9
endmodule

// File: rtl/txint_select.sv
// Transmit interrupt source selector: picks one of four events and emits a
// single-cycle registered interrupt pulse.
// Assumes: all inputs except fsync_i are synchronous to clk.
module txint_select
    import txint_pkg::*;
#(
    parameter int BLK_CHANS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_we_i,
    input  logic [1:0] sel_i,
    input  logic       xrdy_i,
    input  logic       mc_en_i,
    input  logic       slot_stb_i,
    input  logic       slot_eof_i,
    input  logic       fsync_i,
    input  logic       syncerr_set_i,
    input  logic       syncerr_clr_i,
    input  logic       xmit_rst_n_i,
    output logic       xint_o,
    output logic       syncerr_o
);
    txi_sel_e sel_q;
    logic     rdy_prev_q;
    logic     rdy_evt, blk_evt, fs_evt, err_evt;
    logic     evt;
    logic     xint_q;

    // Hold the software-written source select.
    always_ff @(posedge clk) begin
        if (!rst_n)        sel_q <= TXI_RDY;
        else if (sel_we_i) sel_q <= txi_sel_e'(sel_i);
    end

    // Track the ready level, also in reset, so release makes no false edge.
    always_ff @(posedge clk) begin
        rdy_prev_q <= xrdy_i;
    end

    assign rdy_evt = xrdy_i & ~rdy_prev_q;

    txint_blk_track #(.BLK(BLK_CHANS)) i_blk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_n_i (xmit_rst_n_i),
        .en_i    (mc_en_i),
        .stb_i   (slot_stb_i),
        .eof_i   (slot_eof_i),
        .evt_o   (blk_evt)
    );

    txint_fs_sync #(.STAGES(SYNC_STAGES)) i_fs (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (fsync_i),
        .rise_o  (fs_evt)
    );

    txint_err_flag i_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (syncerr_set_i),
        .clr_i   (syncerr_clr_i),
        .flag_o  (syncerr_o),
        .rise_o  (err_evt)
    );

    // Route the selected source to the interrupt register.
    always_comb begin
        unique case (sel_q)
            TXI_RDY: evt = rdy_evt;
            TXI_BLK: evt = blk_evt;
            TXI_FS:  evt = fs_evt;
            TXI_ERR: evt = err_evt;
            default: evt = 1'b0;
        endcase
    end

    // Register the interrupt so it is a clean one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) xint_q <= 1'b0;
        else        xint_q <= evt;
    end

    assign xint_o = xint_q;

    AST_SEL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (sel_q == TXI_RDY && !xint_o)); // R1
    AST_RDY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == TXI_RDY && !$past(sel_we_i) && xint_o) |-> $past(xrdy_i)); // R2
    AST_NOMC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == TXI_BLK && !mc_en_i) |=> !xint_o); // R5
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == TXI_ERR && !$past(sel_we_i) && xint_o) |-> $past(syncerr_set_i)); // R8
endmodule

// File: tb/test_txint_select.sv
module test_txint_select;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_we_i = 1'b0;
    logic [1:0] sel_i = 2'b00;
    logic       xrdy_i = 1'b0;
    logic       mc_en_i = 1'b0;
    logic       slot_stb_i = 1'b0;
    logic       slot_eof_i = 1'b0;
    logic       fsync_i = 1'b0;
    logic       syncerr_set_i = 1'b0;
    logic       syncerr_clr_i = 1'b0;
    logic       xmit_rst_n_i = 1'b1;
    logic       xint_o;
    logic       syncerr_o;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    txint_select i_txint_select (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel_we_i      (sel_we_i),
        .sel_i         (sel_i),
        .xrdy_i        (xrdy_i),
        .mc_en_i       (mc_en_i),
        .slot_stb_i    (slot_stb_i),
        .slot_eof_i    (slot_eof_i),
        .fsync_i       (fsync_i),
        .syncerr_set_i (syncerr_set_i),
        .syncerr_clr_i (syncerr_clr_i),
        .xmit_rst_n_i  (xmit_rst_n_i),
        .xint_o        (xint_o),
        .syncerr_o     (syncerr_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_sel(input logic [1:0] v);
        sel_i = v; sel_we_i = 1'b1;
        step();
        sel_we_i = 1'b0;
    endtask

    // One slot strobe; returns xint_o in the cycle after the strobe.
    task automatic strobe(input logic eof, output logic got);
        slot_stb_i = 1'b1; slot_eof_i = eof;
        step();
        got = xint_o;
        slot_stb_i = 1'b0; slot_eof_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 xint after reset", xint_o, 1'b0);
        chk("R1 syncerr after reset", syncerr_o, 1'b0);
        xrdy_i = 1'b1; step();
        chk("R1 default select is ready edge", xint_o, 1'b1);
        step();
        chk("R1 pulse one cycle", xint_o, 1'b0);
        xrdy_i = 1'b0; step();
    endtask

    task automatic t_rdy();
        xrdy_i = 1'b1; step();
        chk("R2 rise pulse", xint_o, 1'b1);
        step(); step();
        chk("R2 held high no pulse", xint_o, 1'b0);
        xrdy_i = 1'b0; step();
        chk("R2 fall no pulse", xint_o, 1'b0);
        xrdy_i = 1'b1; step();
        chk("R2 second rise", xint_o, 1'b1);
        xrdy_i = 1'b0; step();
    endtask

    task automatic t_blk();
        logic g;
        set_sel(2'b01);
        mc_en_i = 1'b1;
        for (int i = 1; i <= 32; i++) begin
            strobe(1'b0, g);
            chk("R3 block boundary", g, (i == 16 || i == 32));
        end
    endtask

    task automatic t_eof();
        logic g;
        for (int i = 0; i < 5; i++) strobe(1'b0, g);
        strobe(1'b1, g);
        chk("R4 end of frame pulse", g, 1'b1);
        for (int i = 1; i <= 16; i++) begin
            strobe(1'b0, g);
            chk("R4 count restarted after frame end", g, (i == 16));
        end
        for (int i = 0; i < 15; i++) strobe(1'b0, g);
        strobe(1'b1, g);
        chk("R4 frame end on boundary pulse", g, 1'b1);
        step();
        chk("R4 frame end on boundary single", xint_o, 1'b0);
        for (int i = 1; i <= 16; i++) begin
            strobe(1'b0, g);
            chk("R4 restart after coincident end", g, (i == 16));
        end
    endtask

    task automatic t_nomc();
        logic g;
        mc_en_i = 1'b0;
        for (int i = 1; i <= 20; i++) begin
            strobe(i == 20, g);
            chk("R5 no multichannel no pulse", g, 1'b0);
        end
    endtask

    task automatic t_xrst();
        logic g;
        mc_en_i = 1'b1;
        for (int i = 0; i < 10; i++) strobe(1'b0, g);
        xmit_rst_n_i = 1'b0; step();
        xmit_rst_n_i = 1'b1;
        for (int i = 1; i <= 16; i++) begin
            strobe(1'b0, g);
            chk("R11 count cleared by transmitter reset", g, (i == 16));
        end
        mc_en_i = 1'b0;
    endtask

    // Raise fsync, check the pulse in the third cycle only, then drop it.
    task automatic fs_pulse(input string req);
        fsync_i = 1'b1;
        for (int c = 1; c <= 6; c++) begin
            step();
            chk(req, xint_o, (c == 3));
        end
        fsync_i = 1'b0;
        step(); step(); step();
    endtask

    task automatic t_fs();
        set_sel(2'b10);
        fs_pulse("R6 frame sync pulse");
        fs_pulse("R6 second frame sync pulse");
    endtask

    task automatic t_fs_rst();
        xmit_rst_n_i = 1'b0;
        fs_pulse("R7 frame sync in transmitter reset");
        xmit_rst_n_i = 1'b1;
    endtask

    task automatic t_err();
        set_sel(2'b11);
        syncerr_set_i = 1'b1; step();
        chk("R8 error set pulse", xint_o, 1'b1);
        chk("R9 flag set", syncerr_o, 1'b1);
        syncerr_set_i = 1'b0; step();
        chk("R8 pulse one cycle", xint_o, 1'b0);
        syncerr_set_i = 1'b1; step();
        chk("R8 set while set no pulse", xint_o, 1'b0);
        syncerr_set_i = 1'b0; step(); step();
        chk("R9 flag sticky", syncerr_o, 1'b1);
        syncerr_clr_i = 1'b1; step();
        chk("R9 flag cleared", syncerr_o, 1'b0);
        syncerr_set_i = 1'b1; step();
        chk("R9 set wins over clear", syncerr_o, 1'b1);
        syncerr_set_i = 1'b0; step();
        chk("R9 clear after set", syncerr_o, 1'b0);
        syncerr_clr_i = 1'b0;
    endtask

    task automatic t_other();
        set_sel(2'b00);
        syncerr_set_i = 1'b1; step();
        chk("R9 flag set in select 00", syncerr_o, 1'b1);
        chk("R10 error ignored in select 00", xint_o, 1'b0);
        syncerr_set_i = 1'b0;
        fsync_i = 1'b1;
        for (int c = 0; c < 5; c++) begin
            step();
            chk("R10 frame sync ignored in select 00", xint_o, 1'b0);
        end
        fsync_i = 1'b0;
        syncerr_clr_i = 1'b1; step(); syncerr_clr_i = 1'b0;
        set_sel(2'b11);
        xrdy_i = 1'b1; step();
        chk("R10 ready ignored in select 11", xint_o, 1'b0);
        xrdy_i = 1'b0; step();
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: got hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_rdy();
        t_blk();
        t_eof();
        t_nomc();
        t_xrst();
        t_fs();
        t_fs_rst();
        t_err();
        t_other();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule